// File: doc/BRIEF.md
# Dual Multi-Mode Timer/Counter

This block holds two timer/counter channels behind one byte-wide register port. One shared mode register and one shared control register set up both channels. Each channel has a low and a high count byte. For each channel, software picks one of four counting layouts. It also picks the source of counts: either a machine-cycle tick, which is the clock divided by `PRESCALE`, or falling edges on an external count pin. Software can also make counting depend on the level of a gate pin.

When a channel wraps, its overflow flag is set. The flags leave the block on `ovfFlag` for an interrupt controller. When the interrupt is taken, `intAck` clears the matching flag. In the split layout, channel 0 becomes two independent 8-bit counters. The upper half borrows channel 1's run bit and channel 1's overflow flag.

Register addresses are: 0 mode, 1 control, 2 channel-0 low, 3 channel-0 high, 4 channel-1 low, 5 channel-1 high. Addresses 6 and 7 read as zero and ignore writes.

Top module: `timer_pair`

## Requirements
- R1: After reset, every register reads 0x00 and both `ovfFlag` bits are 0.
- R2: Every register reads back what was last written to it. Control bits are: bit 7 = channel-1 flag, bit 6 = channel-1 run, bit 5 = channel-0 flag, bit 4 = channel-0 run. Bits 3..0 of the control register read as 0.
- R3: Mode bits 3..0 belong to channel 0 and bits 7..4 to channel 1. Within a nibble, bit 3 is gate, bit 2 is source select and bits 1..0 are the layout. With source select 0, a running channel advances exactly once per `PRESCALE` clocks. A channel whose run bit is 0 holds its count.
- R4: With source select 1, the channel counts falling edges of its synchronized count pin. A count is taken at the next machine-cycle tick, so at most one count happens per tick. A rising edge or a steady level does not count.
- R5: With the gate bit at 1, a channel counts only while its run bit is 1 and its gate pin is high. With the gate bit at 0, the gate pin is ignored.
- R6: Layout 00 is a 13-bit counter. Low bits 4..0 form the lower part and the high byte the upper part. Low bits 7..5 are left untouched. Wrapping from all ones sets the flag.
- R7: Layout 01 is a 16-bit counter. Wrapping from 0xFFFF to 0x0000 sets the flag.
- R8: Layout 10 counts in the low byte only. When the low byte wraps, it is loaded from the high byte and the flag is set.
- R9: Layout 11 on channel 0 splits it in two. The low byte counts under channel 0's run, gate and source bits and sets flag 0. The high byte counts ticks while channel 1's run bit is 1 and sets flag 1. While the split is active, an overflow of channel 1 does not set flag 1.
- R10: Channel 1 set to layout 11 holds its count.
- R11: A pulse on `intAck[n]` clears flag n. Software may write either flag to 0 or to 1.
- R12: A register write to a count byte in the same cycle as an increment of that channel wins. The written value stands and no increment is applied.
- R13: A flag set by an overflow wins over a software clear of that flag in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 3 | Register address for read and write |
| regWrData | input | 8 | Write data |
| regRdData | output | 8 | Read data of the addressed register, combinational |
| gatePin | input | 2 | Per-channel gate level, bit n for channel n |
| countPin | input | 2 | Per-channel external count pins |
| intAck | input | 2 | Per-channel flag clear when the interrupt is taken |
| ovfFlag | output | 2 | Per-channel overflow flags |

## Verification
The bench builds the block with `PRESCALE` = 4 and `SYNC_STAGES` = 2. The short machine cycle makes many-tick runs and a 16-bit wrap from a preloaded count cheap. The bench finds the tick phase by watching the count byte change. It then places register writes on the exact increment edge, which is the only way to reach the write-versus-increment and overflow-versus-clear collisions. The stop/start run window is an exact multiple of four clocks, so timer-mode counts are exact whatever the tick phase.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  localparam logic [1:0] LAYOUT_13BIT  = 2'b00;
  localparam logic [1:0] LAYOUT_16BIT  = 2'b01;
  localparam logic [1:0] LAYOUT_RELOAD = 2'b10;
  localparam logic [1:0] LAYOUT_SPLIT  = 2'b11;

  localparam logic [2:0] ADDR_MODE = 3'd0;
  localparam logic [2:0] ADDR_CTRL = 3'd1;

  typedef struct packed {
    logic step0;      // channel 0 advances this cycle
    logic step1;      // channel 1 advances this cycle
    logic stepSplit;  // upper half of split channel 0 advances
  } tmrStrobes_t;

  typedef struct packed {
    logic [7:0] lo;
    logic [7:0] hi;
    logic       ovf;
  } tmrCount_t;

  function automatic tmrCount_t countNext(input logic [1:0] layout,
                                          input logic [7:0] lo,
                                          input logic [7:0] hi);
    tmrCount_t r;
    r.lo  = lo;
    r.hi  = hi;
    r.ovf = 1'b0;
    case (layout)
      LAYOUT_13BIT: begin
        if (lo[4:0] == 5'h1f) begin
          r.lo[4:0] = 5'h00;
          r.hi      = hi + 8'd1;
          r.ovf     = (hi == 8'hff);
        end else begin
          r.lo[4:0] = lo[4:0] + 5'd1;
        end
      end
      LAYOUT_16BIT: begin
        {r.hi, r.lo} = {hi, lo} + 16'd1;
        r.ovf        = &{hi, lo};
      end
      LAYOUT_RELOAD: begin
        if (&lo) begin
          r.lo  = hi;
          r.ovf = 1'b1;
        end else begin
          r.lo = lo + 8'd1;
        end
      end
      default: begin
        r.lo  = lo + 8'd1;
        r.ovf = &lo;
      end
    endcase
    return r;
  endfunction

endpackage

// File: rtl/tmr_ctrl.sv
module tmr_ctrl
  import tmr_pkg::*;
#(
  parameter int PRESCALE    = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [7:0]  modeReg,
  input  logic [1:0]  runBits,
  input  logic [1:0]  gatePin,
  input  logic [1:0]  countPin,
  output tmrStrobes_t strb
);

  localparam int PRE_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(PRESCALE - 1);

  logic [PRE_W-1:0] preCnt;
  logic             mcTick;
  logic [1:0]       chStep;

  assign mcTick = (preCnt == PRE_LAST);

  always_ff @(posedge clk) begin
    if (!rstN) preCnt <= '0;
    else       preCnt <= mcTick ? '0 : preCnt + PRE_W'(1);
  end

  for (genvar ch = 0; ch < 2; ch++) begin : g_chan
    logic [SYNC_STAGES-1:0] syncQ;
    logic                   prevQ;
    logic                   pendQ;
    logic                   fallNow;
    logic                   evNow;
    logic [3:0]             nib;
    logic                   gateOk;
    logic                   srcOk;

    assign fallNow = prevQ & ~syncQ[SYNC_STAGES-1];
    assign evNow   = pendQ | fallNow;
    assign nib     = modeReg[ch*4 +: 4];
    assign gateOk  = ~nib[3] | gatePin[ch];
    assign srcOk   = nib[2] ? evNow : 1'b1;
    assign chStep[ch] = runBits[ch] & gateOk & srcOk & mcTick;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        syncQ <= '0;
        prevQ <= 1'b0;
        pendQ <= 1'b0;
      end else begin
        syncQ <= {syncQ[SYNC_STAGES-2:0], countPin[ch]};
        prevQ <= syncQ[SYNC_STAGES-1];
        pendQ <= mcTick ? 1'b0 : evNow;
      end
    end

    // an event is only held over while no tick has consumed it
    assert_pend_off_tick_R4: assert property (@(posedge clk) disable iff (!rstN)
      $rose(pendQ) |-> $past(!mcTick));
  end

  assign strb.step0     = chStep[0];
  assign strb.step1     = chStep[1] & (modeReg[5:4] != LAYOUT_SPLIT);
  assign strb.stepSplit = (modeReg[1:0] == LAYOUT_SPLIT) & runBits[1] & mcTick;

  if (PRESCALE > 1) begin : g_tickChk
    assert_tick_spacing_R3: assert property (@(posedge clk) disable iff (!rstN)
      mcTick |=> !mcTick);
  end

endmodule

// File: rtl/tmr_datapath.sv
module tmr_datapath
  import tmr_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic [2:0]  addr,
  input  logic [7:0]  wrData,
  input  logic [1:0]  intAck,
  input  tmrStrobes_t strb,
  output logic [7:0]  rdData,
  output logic [7:0]  modeReg,
  output logic [1:0]  runBits,
  output logic [1:0]  tfBits
);

  logic [7:0] modeQ;
  logic [1:0] trQ;
  logic [1:0] tfQ;
  logic [7:0] loQ [2];
  logic [7:0] hiQ [2];
  logic [1:0] wrLo;
  logic [1:0] wrHi;
  logic [1:0] stepEff;
  logic [1:0] ovfCh;
  logic [1:0] tfSet;
  logic       wrCtrl;
  logic       splitOn;
  logic       splitStep;
  logic       splitOvf;
  tmrCount_t  nxt [2];

  assign wrCtrl    = wrEn && (addr == ADDR_CTRL);
  assign splitOn   = (modeQ[1:0] == LAYOUT_SPLIT);
  assign splitStep = strb.stepSplit & ~wrHi[0];
  assign splitOvf  = splitStep & (&hiQ[0]);

  assign stepEff[0] = strb.step0 & ~wrLo[0] & ~(wrHi[0] & ~splitOn);
  assign stepEff[1] = strb.step1 & ~wrLo[1] & ~wrHi[1];

  for (genvar ch = 0; ch < 2; ch++) begin : g_cnt
    localparam logic [2:0] LO_ADDR = 3'(2 + 2 * ch);
    localparam logic [2:0] HI_ADDR = 3'(3 + 2 * ch);

    assign wrLo[ch]  = wrEn && (addr == LO_ADDR);
    assign wrHi[ch]  = wrEn && (addr == HI_ADDR);
    assign nxt[ch]   = countNext(modeQ[ch*4 +: 2], loQ[ch], hiQ[ch]);
    assign ovfCh[ch] = stepEff[ch] & nxt[ch].ovf;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        loQ[ch] <= 8'h00;
        hiQ[ch] <= 8'h00;
      end else begin
        if (wrLo[ch])         loQ[ch] <= wrData;
        else if (stepEff[ch]) loQ[ch] <= nxt[ch].lo;

        if (wrHi[ch])                      hiQ[ch] <= wrData;
        else if (ch == 0 && splitStep)     hiQ[ch] <= hiQ[ch] + 8'd1;
        else if (stepEff[ch])              hiQ[ch] <= nxt[ch].hi;
      end
    end

    always_ff @(posedge clk) begin
      if (!rstN)               tfQ[ch] <= 1'b0;
      else if (tfSet[ch])      tfQ[ch] <= 1'b1;
      else if (wrCtrl)         tfQ[ch] <= wrData[5 + 2*ch];
      else if (intAck[ch])     tfQ[ch] <= 1'b0;
    end

    assert_flag_on_ovf_R13: assert property (@(posedge clk) disable iff (!rstN)
      tfSet[ch] |=> tfQ[ch]);

    assert_ack_clears_R11: assert property (@(posedge clk) disable iff (!rstN)
      (intAck[ch] && !tfSet[ch] && !wrCtrl) |=> !tfQ[ch]);
  end

  assign tfSet[0] = ovfCh[0];
  assign tfSet[1] = splitOn ? splitOvf : ovfCh[1];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeQ <= 8'h00;
      trQ   <= 2'b00;
    end else begin
      if (wrEn && addr == ADDR_MODE) modeQ <= wrData;
      if (wrCtrl)                    trQ   <= {wrData[6], wrData[4]};
    end
  end

  always_comb begin
    case (addr)
      3'd0:    rdData = modeQ;
      3'd1:    rdData = {tfQ[1], trQ[1], tfQ[0], trQ[0], 4'h0};
      3'd2:    rdData = loQ[0];
      3'd3:    rdData = hiQ[0];
      3'd4:    rdData = loQ[1];
      3'd5:    rdData = hiQ[1];
      default: rdData = 8'h00;
    endcase
  end

  assign modeReg = modeQ;
  assign runBits = trQ;
  assign tfBits  = tfQ;

  assert_hold_idle_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.step0 && !strb.stepSplit && !wrLo[0] && !wrHi[0]) |=> $stable({hiQ[0], loQ[0]}));

  assert_ch1_split_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    (modeQ[5:4] == LAYOUT_SPLIT && !wrLo[1] && !wrHi[1]) |=> $stable({hiQ[1], loQ[1]}));

endmodule

// File: rtl/timer_pair.sv
module timer_pair
  import tmr_pkg::*;
#(
  parameter int PRESCALE    = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       regWrEn,
  input  logic [2:0] regAddr,
  input  logic [7:0] regWrData,
  output logic [7:0] regRdData,
  input  logic [1:0] gatePin,
  input  logic [1:0] countPin,
  input  logic [1:0] intAck,
  output logic [1:0] ovfFlag
);

  tmrStrobes_t strb;
  logic [7:0]  modeReg;
  logic [1:0]  runBits;

  tmr_ctrl #(
    .PRESCALE    (PRESCALE),
    .SYNC_STAGES (SYNC_STAGES)
  ) i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .modeReg  (modeReg),
    .runBits  (runBits),
    .gatePin  (gatePin),
    .countPin (countPin),
    .strb     (strb)
  );

  tmr_datapath i_dp (
    .clk     (clk),
    .rstN    (rstN),
    .wrEn    (regWrEn),
    .addr    (regAddr),
    .wrData  (regWrData),
    .intAck  (intAck),
    .strb    (strb),
    .rdData  (regRdData),
    .modeReg (modeReg),
    .runBits (runBits),
    .tfBits  (ovfFlag)
  );

endmodule

// File: tb/test_timer_pair.sv
`timescale 1ns/1ps
module test_timer_pair;

  localparam int P = 4;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       regWrEn = 1'b0;
  logic [2:0] regAddr = 3'd0;
  logic [7:0] regWrData = 8'h00;
  logic [7:0] regRdData;
  logic [1:0] gatePin = 2'b00;
  logic [1:0] countPin = 2'b00;
  logic [1:0] intAck = 2'b00;
  logic [1:0] ovfFlag;

  int nRun = 0;
  int nFail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  timer_pair #(.PRESCALE(P), .SYNC_STAGES(2)) i_timer_pair (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .gatePin(gatePin),
    .countPin(countPin), .intAck(intAck), .ovfFlag(ovfFlag)
  );

  // layout, preload lo, preload hi, events, expected lo, expected hi, expected flag
  typedef struct packed {
    logic [1:0] lay;
    logic [7:0] lo;
    logic [7:0] hi;
    logic [2:0] ev;
    logic [7:0] eLo;
    logic [7:0] eHi;
    logic       eTf;
  } vec_t;

  localparam vec_t VEC [7] = '{
    '{2'b01, 8'hFE, 8'hFF, 3'd3, 8'h01, 8'h00, 1'b1},
    '{2'b01, 8'hFF, 8'h12, 3'd1, 8'h00, 8'h13, 1'b0},
    '{2'b10, 8'hFE, 8'h80, 3'd3, 8'h81, 8'h80, 1'b1},
    '{2'b00, 8'hFE, 8'hFF, 3'd2, 8'hE0, 8'h00, 1'b1},
    '{2'b00, 8'h1F, 8'h05, 3'd1, 8'h00, 8'h06, 1'b0},
    '{2'b11, 8'hFF, 8'h33, 3'd2, 8'h01, 8'h33, 1'b1},
    '{2'b10, 8'h10, 8'h00, 3'd4, 8'h14, 8'h00, 1'b0}
  };

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nRun++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = regRdData;
  endtask

  task automatic rdChk(input logic [2:0] a, input logic [7:0] exp, input string tag);
    logic [7:0] v;
    rd(a, v);
    chk(v == exp, tag, v, exp);
  endtask

  // run bits set for exactly 'cycles' clock edges, then all control bits cleared
  task automatic runFor(input logic [7:0] ctrl, input int cycles);
    wr(3'd1, ctrl);
    repeat (cycles - 1) @(negedge clk);
    regWrEn = 1'b1; regAddr = 3'd1; regWrData = 8'h00;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic pulse(input int ch);
    @(negedge clk);
    countPin[ch] = 1'b1;
    repeat (2*P) @(negedge clk);
    countPin[ch] = 1'b0;
    repeat (2*P) @(negedge clk);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nRun++;
    nFail++;
    $display("FAIL watchdog: actual 0x0 expected 0x1");
    finishRun();
  end

  initial begin
    logic [7:0] v;
    string tag;
    repeat (4) @(negedge clk);
    rstN = 1'b1;

    // R1: reset state
    for (int a = 0; a < 6; a++) rdChk(3'(a), 8'h00, "R1 reset register");
    chk(ovfFlag == 2'b00, "R1 reset flags", ovfFlag, 0);

    // R2: readback, control low nibble reads zero; R11 software flag write and ack
    wr(3'd4, 8'hA5);
    rdChk(3'd4, 8'hA5, "R2 readback ch1 low");
    wr(3'd1, 8'hAF);
    rdChk(3'd1, 8'hA0, "R2 control readback");
    chk(ovfFlag == 2'b11, "R11 software flag set", ovfFlag, 3);
    @(negedge clk); intAck = 2'b11;
    @(negedge clk); intAck = 2'b00;
    chk(ovfFlag == 2'b00, "R11 ack clears flags", ovfFlag, 0);
    wr(3'd1, 8'h00);

    // vector table: channel 0 counting pin events in each layout
    foreach (VEC[i]) begin
      case (VEC[i].lay)
        2'b00:   tag = "R6 13-bit layout";
        2'b01:   tag = "R7 16-bit layout";
        2'b10:   tag = "R8 reload layout";
        default: tag = "R9 split low half";
      endcase
      wr(3'd1, 8'h00);
      wr(3'd0, {6'b000001, VEC[i].lay});
      wr(3'd2, VEC[i].lo);
      wr(3'd3, VEC[i].hi);
      wr(3'd1, 8'h10);
      for (int e = 0; e < int'(VEC[i].ev); e++) pulse(0);
      repeat (3*P) @(negedge clk);
      rdChk(3'd2, VEC[i].eLo, {tag, " low (R4)"});
      rdChk(3'd3, VEC[i].eHi, {tag, " high"});
      chk(ovfFlag[0] == VEC[i].eTf, {tag, " flag (R11)"}, ovfFlag[0], VEC[i].eTf);
      wr(3'd1, 8'h00);
    end

    // R3: timer source on each channel
    wr(3'd0, 8'h10); wr(3'd4, 8'h00); wr(3'd5, 8'h00);
    runFor(8'h40, 5*P);
    rdChk(3'd4, 8'h05, "R3 ch1 tick count");
    wr(3'd0, 8'h01); wr(3'd2, 8'h00); wr(3'd3, 8'h00);
    runFor(8'h10, 7*P);
    rdChk(3'd2, 8'h07, "R3 ch0 tick count");
    repeat (3*P) @(negedge clk);
    rdChk(3'd2, 8'h07, "R3 stopped channel holds");

    // R5: gate
    wr(3'd0, 8'h09); wr(3'd2, 8'h00);
    gatePin[0] = 1'b0;
    runFor(8'h10, 6*P);
    rdChk(3'd2, 8'h00, "R5 gate low blocks");
    gatePin[0] = 1'b1;
    runFor(8'h10, 6*P);
    rdChk(3'd2, 8'h06, "R5 gate high counts");
    gatePin[0] = 1'b0;

    // R4: rising edge and level do not count, falling edge does
    wr(3'd0, 8'h05); wr(3'd2, 8'h00); wr(3'd1, 8'h10);
    @(negedge clk); countPin[0] = 1'b1;
    repeat (4*P) @(negedge clk);
    rdChk(3'd2, 8'h00, "R4 rising edge ignored");
    countPin[0] = 1'b0;
    repeat (3*P) @(negedge clk);
    rdChk(3'd2, 8'h01, "R4 falling edge counted");
    wr(3'd1, 8'h00);

    // R10: channel 1 in layout 11 holds
    wr(3'd0, 8'h30); wr(3'd4, 8'h00); wr(3'd5, 8'h00);
    runFor(8'h40, 4*P);
    rdChk(3'd4, 8'h00, "R10 ch1 split layout low holds");
    rdChk(3'd5, 8'h00, "R10 ch1 split layout high holds");

    // R9: split upper half driven by channel 1 run bit, flag 1 borrowed
    wr(3'd0, 8'h13); wr(3'd2, 8'h00); wr(3'd3, 8'hFE);
    wr(3'd4, 8'hFF); wr(3'd5, 8'hFF);
    runFor(8'h40, P);
    rdChk(3'd3, 8'hFF, "R9 split high advances");
    rdChk(3'd4, 8'h00, "R9 ch1 wrapped");
    chk(ovfFlag[1] == 1'b0, "R9 ch1 wrap does not set flag 1", ovfFlag[1], 0);
    runFor(8'h40, P);
    rdChk(3'd3, 8'h00, "R9 split high wraps");
    chk(ovfFlag[1] == 1'b1, "R9 split high sets flag 1", ovfFlag[1], 1);
    rdChk(3'd2, 8'h00, "R9 split low held without run 0");
    wr(3'd1, 8'h00);

    // R12 / R13: collisions placed on the exact tick edge
    wr(3'd0, 8'h01); wr(3'd2, 8'hF0); wr(3'd3, 8'hFF); wr(3'd1, 8'h10);
    regAddr = 3'd2;
    for (int g = 0; g < 4*P; g++) begin
      @(negedge clk);
      #1;
      if (regRdData != 8'hF0) break;
    end
    chk(regRdData == 8'hF1, "R3 phase search", regRdData, 8'hF1);
    repeat (P-1) @(negedge clk);
    regWrEn = 1'b1; regAddr = 3'd2; regWrData = 8'h40;
    @(negedge clk);
    regWrData = 8'hFF;
    @(negedge clk);
    regWrEn = 1'b0;
    repeat (P-2) @(negedge clk);
    regWrEn = 1'b1; regAddr = 3'd1; regWrData = 8'h10;
    @(negedge clk);
    regWrEn = 1'b0;
    chk(ovfFlag[0] == 1'b1, "R13 overflow beats software clear", ovfFlag[0], 1);
    rdChk(3'd3, 8'h00, "R7 wrap high on tick");
    wr(3'd1, 8'h00);
    rd(3'd2, v);
    chk(v == 8'h00 || v == 8'h01, "R12 write wins then wraps", v, 0);

    // R12 direct: written value stands at a tick edge
    wr(3'd2, 8'hF0); wr(3'd1, 8'h10);
    regAddr = 3'd2;
    for (int g = 0; g < 4*P; g++) begin
      @(negedge clk);
      #1;
      if (regRdData != 8'hF0) break;
    end
    repeat (P-1) @(negedge clk);
    regWrEn = 1'b1; regAddr = 3'd2; regWrData = 8'h40;
    @(negedge clk);
    regWrEn = 1'b0;
    #1;
    chk(regRdData == 8'h40, "R12 write beats increment", regRdData, 8'h40);
    wr(3'd1, 8'h00);

    finishRun();
  end

endmodule